// File: doc/BRIEF.md
# Packet Descriptor Queue Register Interface

This block is the software-facing front end of a network DMA controller. Software describes each transmit packet or empty receive buffer with two register writes. The first write sets a length. The second write supplies a buffer address, and that write pushes the address together with the stored length into the transmit or receive queue. A DMA engine collects pending descriptors through a valid/ready request port. It later returns one completion per descriptor: a status code, plus the received length for the receive side. Software reads a queue register to pop the oldest completion status.

Each direction uses one circular ring of DEPTH slots. A slot is occupied from the moment its descriptor is pushed until software pops its completion. Within that window the slot passes through three states: pending, handed to the DMA engine, and completed. A status register reports completion availability, sticky overflow flags and the occupancy of both rings. A capacity register reports DEPTH.

Top module: `pdq_regif`

## Requirements
- R1: A write to index 0 (transmit length) or index 2 (receive length) stores wdata[LEN_W-1:0]. A write to index 1 (transmit queue) or index 3 (receive queue) pushes wdata[ADDR_W-1:0] together with the stored length. The stored length stays in force for later pushes until it is rewritten.
- R2: tx_req_valid is high from the cycle after a push for as long as a transmit descriptor has not yet been handed off. tx_req_addr and tx_req_len show the oldest such descriptor. The descriptor is handed off on a clock edge where tx_req_valid and tx_req_ready are both high.
- R3: rx_req_valid is high only while rx_pkt_present is high and at least one receive buffer descriptor has not been handed off. The handoff follows the same rule as R2.
- R4: A completion (cpl_valid high) belongs to the oldest descriptor that has been handed off but not yet completed. A completion that arrives while no descriptor is in flight is ignored. Pops return completions in push order.
- R5: A read of index 1 or 3 returns the oldest completed status, zero-extended, on reg_rdata in the same cycle, and consumes that status at the clock edge. When nothing has completed, the read returns 0 and changes no state. Back-to-back reads return successive entries.
- R6: A read of index 2 returns the received length of the oldest receive completion that has not been popped, and it does not pop. The read returns 0 when no receive completion is available.
- R7: Ring occupancy counts descriptors from push to pop. A push when occupancy equals DEPTH is dropped, even if a pop happens in the same cycle, and the ring contents stay unchanged. Such a push sets a sticky overflow flag that is cleared only by reset.
- R8: A read of index 4 returns the status word: bit0 = transmit completion available, bit1 = receive completion available, bit2 = transmit overflow, bit3 = receive overflow, bits[15:8] = transmit occupancy, bits[23:16] = receive occupancy. All other bits are 0.
- R9: A read of index 5 returns DEPTH. Reads of indices 0, 6 and 7 return 0. reg_rdata is 0 whenever reg_rd is low.
- R10: After reset both rings are empty, both request valids are low, the stored lengths are 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on queue indices) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| tx_req_valid | output | 1 | Transmit descriptor offered to the DMA engine |
| tx_req_ready | input | 1 | DMA engine takes the transmit descriptor |
| tx_req_addr | output | ADDR_W | Transmit buffer address |
| tx_req_len | output | LEN_W | Transmit packet length |
| tx_cpl_valid | input | 1 | Transmit completion strobe |
| tx_cpl_status | input | STAT_W | Transmit completion code (1 = success) |
| rx_pkt_present | input | 1 | An incoming packet waits for a buffer |
| rx_req_valid | output | 1 | Receive buffer descriptor offered |
| rx_req_ready | input | 1 | DMA engine takes the receive descriptor |
| rx_req_addr | output | ADDR_W | Receive buffer address |
| rx_req_len | output | LEN_W | Receive buffer size |
| rx_cpl_valid | input | 1 | Receive completion strobe |
| rx_cpl_status | input | STAT_W | Receive completion code (1 = success) |
| rx_cpl_len | input | LEN_W | Received packet length |

## Verification
The assertions assume that the DMA engine sends a completion only for a descriptor it has actually taken. The stimulus respects this: it raises a completion strobe only while its own model shows a descriptor in flight. The assertions make no assumptions about software, so software pushes into full rings are deliberately provoked. The bench also reads unpopulated indices at random. The reference model is compared on every clock, so its expected values already include the dropped pushes and the ignored empty pops.

// File: rtl/pdq_pkg.sv
package pdq_pkg;

   localparam int unsigned REG_DATA_W = 32;
   localparam int unsigned REG_IDX_W  = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      RI_TX_LEN  = 3'd0,
      RI_TX_QUE  = 3'd1,
      RI_RX_LEN  = 3'd2,
      RI_RX_QUE  = 3'd3,
      RI_STATUS  = 3'd4,
      RI_CAPAC   = 3'd5
   } reg_idx_e;

   localparam int unsigned ST_TX_AVAIL = 0;
   localparam int unsigned ST_RX_AVAIL = 1;
   localparam int unsigned ST_TX_OVF   = 2;
   localparam int unsigned ST_RX_OVF   = 3;
   localparam int unsigned ST_TX_OCC   = 8;
   localparam int unsigned ST_RX_OCC   = 16;
   localparam int unsigned ST_OCC_W    = 8;

endpackage

// File: rtl/pdq_desc_ring.sv
module pdq_desc_ring #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned STAT_W    = 8,
   parameter int unsigned DEPTH     = 4,
   parameter bit          STORE_LEN = 1'b0,
   localparam int unsigned IDX_W    = $clog2(DEPTH),
   localparam int unsigned PTR_W    = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic [LEN_W-1:0]  push_len_i,
   input  logic              pop_i,
   input  logic              req_allow_i,
   input  logic              req_ready_i,
   output logic              req_valid_o,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [LEN_W-1:0]  req_len_o,
   input  logic              cpl_valid_i,
   input  logic [STAT_W-1:0] cpl_status_i,
   input  logic [LEN_W-1:0]  cpl_len_i,
   output logic              head_valid_o,
   output logic [STAT_W-1:0] head_status_o,
   output logic [LEN_W-1:0]  head_len_o,
   output logic [PTR_W-1:0]  count_o,
   output logic              overflow_o
);

   logic [PTR_W-1:0]  wr_ptr, iss_ptr, done_ptr, rd_ptr;
   logic [ADDR_W-1:0] addr_mem [DEPTH];
   logic [LEN_W-1:0]  len_mem  [DEPTH];
   logic [STAT_W-1:0] stat_mem [DEPTH];

   logic full, pend, fire, cpl_ok, push_ok, pop_ok;
   logic [IDX_W-1:0] wr_idx, iss_idx, done_idx, rd_idx;

   assign wr_idx   = wr_ptr[IDX_W-1:0];
   assign iss_idx  = iss_ptr[IDX_W-1:0];
   assign done_idx = done_ptr[IDX_W-1:0];
   assign rd_idx   = rd_ptr[IDX_W-1:0];

   assign count_o      = wr_ptr - rd_ptr;
   assign full         = (count_o == PTR_W'(DEPTH));
   assign pend         = (iss_ptr != wr_ptr);
   assign head_valid_o = (rd_ptr != done_ptr);
   assign push_ok      = push_i && !full;
   assign pop_ok       = pop_i && head_valid_o;
   assign fire         = pend && req_allow_i && req_ready_i;
   assign cpl_ok       = cpl_valid_i && (done_ptr != iss_ptr);

   assign req_valid_o   = pend && req_allow_i;
   assign req_addr_o    = addr_mem[iss_idx];
   assign req_len_o     = len_mem[iss_idx];
   assign head_status_o = stat_mem[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         iss_ptr    <= '0;
         done_ptr   <= '0;
         rd_ptr     <= '0;
         overflow_o <= 1'b0;
      end else begin
         if (push_ok)          wr_ptr   <= wr_ptr + 1'b1;
         if (fire)             iss_ptr  <= iss_ptr + 1'b1;
         if (cpl_ok)           done_ptr <= done_ptr + 1'b1;
         if (pop_ok)           rd_ptr   <= rd_ptr + 1'b1;
         if (push_i && full)   overflow_o <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         addr_mem[wr_idx] <= push_addr_i;
         len_mem[wr_idx]  <= push_len_i;
      end
      if (cpl_ok) stat_mem[done_idx] <= cpl_status_i;
   end

   generate
      if (STORE_LEN) begin : g_rlen
         logic [LEN_W-1:0] rlen_mem [DEPTH];
         always_ff @(posedge clk) begin
            if (cpl_ok) rlen_mem[done_idx] <= cpl_len_i;
         end
         assign head_len_o = rlen_mem[rd_idx];
      end else begin : g_no_rlen
         logic unused_cpl_len;
         assign unused_cpl_len = ^cpl_len_i;
         assign head_len_o     = '0;
      end
   endgenerate

   // R7: occupancy never exceeds the ring size
   p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= PTR_W'(DEPTH));

   // R7: a push into a full ring leaves the write side untouched and flags it
   p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && count_o == PTR_W'(DEPTH)) |=> (overflow_o && wr_ptr == $past(wr_ptr)));

   // R7: overflow is sticky
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> overflow_o);

   // R5: an accepted pop advances the read side by exactly one
   p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && head_valid_o) |=> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

   // R2: an offered descriptor that is not taken stays offered, unchanged
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !(req_allow_i && req_ready_i)) |=> (pend && $stable(req_addr_o) && $stable(req_len_o)));

endmodule

// File: rtl/pdq_regfile.sv
module pdq_regfile
   import pdq_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned STAT_W = 8,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned PTR_W  = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [REG_IDX_W-1:0]  reg_addr,
   input  logic [REG_DATA_W-1:0] reg_wdata,
   output logic [REG_DATA_W-1:0] reg_rdata,
   output logic [LEN_W-1:0]      tx_len_o,
   output logic [LEN_W-1:0]      rx_len_o,
   output logic                  tx_push_o,
   output logic                  rx_push_o,
   output logic                  tx_pop_o,
   output logic                  rx_pop_o,
   input  logic                  tx_head_valid_i,
   input  logic [STAT_W-1:0]     tx_head_status_i,
   input  logic                  rx_head_valid_i,
   input  logic [STAT_W-1:0]     rx_head_status_i,
   input  logic [LEN_W-1:0]      rx_head_len_i,
   input  logic [PTR_W-1:0]      tx_count_i,
   input  logic [PTR_W-1:0]      rx_count_i,
   input  logic                  tx_ovf_i,
   input  logic                  rx_ovf_i
);

   reg_idx_e idx;
   logic [REG_DATA_W-1:0] status_word;

   assign idx       = reg_idx_e'(reg_addr);
   assign tx_push_o = reg_wr && (idx == RI_TX_QUE);
   assign rx_push_o = reg_wr && (idx == RI_RX_QUE);
   assign tx_pop_o  = reg_rd && (idx == RI_TX_QUE);
   assign rx_pop_o  = reg_rd && (idx == RI_RX_QUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_len_o <= '0;
         rx_len_o <= '0;
      end else if (reg_wr) begin
         if (idx == RI_TX_LEN) tx_len_o <= reg_wdata[LEN_W-1:0];
         if (idx == RI_RX_LEN) rx_len_o <= reg_wdata[LEN_W-1:0];
      end
   end

   always_comb begin
      status_word = '0;
      status_word[ST_TX_AVAIL] = tx_head_valid_i;
      status_word[ST_RX_AVAIL] = rx_head_valid_i;
      status_word[ST_TX_OVF]   = tx_ovf_i;
      status_word[ST_RX_OVF]   = rx_ovf_i;
      status_word[ST_TX_OCC +: ST_OCC_W] = ST_OCC_W'(tx_count_i);
      status_word[ST_RX_OCC +: ST_OCC_W] = ST_OCC_W'(rx_count_i);
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         case (idx)
            RI_TX_QUE: if (tx_head_valid_i) reg_rdata = REG_DATA_W'(tx_head_status_i);
            RI_RX_QUE: if (rx_head_valid_i) reg_rdata = REG_DATA_W'(rx_head_status_i);
            RI_RX_LEN: if (rx_head_valid_i) reg_rdata = REG_DATA_W'(rx_head_len_i);
            RI_STATUS: reg_rdata = status_word;
            RI_CAPAC:  reg_rdata = REG_DATA_W'(DEPTH);
            default:   reg_rdata = '0;
         endcase
      end
   end

   // R5: popping an empty completion queue reads as zero
   p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop_o && !tx_head_valid_i) |-> (reg_rdata == '0));

endmodule

// File: rtl/pdq_regif.sv
module pdq_regif
   import pdq_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned STAT_W = 8,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              tx_req_valid,
   input  logic              tx_req_ready,
   output logic [ADDR_W-1:0] tx_req_addr,
   output logic [LEN_W-1:0]  tx_req_len,
   input  logic              tx_cpl_valid,
   input  logic [STAT_W-1:0] tx_cpl_status,
   input  logic              rx_pkt_present,
   output logic              rx_req_valid,
   input  logic              rx_req_ready,
   output logic [ADDR_W-1:0] rx_req_addr,
   output logic [LEN_W-1:0]  rx_req_len,
   input  logic              rx_cpl_valid,
   input  logic [STAT_W-1:0] rx_cpl_status,
   input  logic [LEN_W-1:0]  rx_cpl_len
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 128) begin : g_bad_depth
         $error("DEPTH must be a power of two between 2 and 128");
      end
      if (ADDR_W > REG_DATA_W || LEN_W > REG_DATA_W || STAT_W > REG_DATA_W) begin : g_bad_width
         $error("address, length and status fields must fit the register word");
      end
   endgenerate

   logic [LEN_W-1:0]  tx_len, rx_len;
   logic              tx_push, rx_push, tx_pop, rx_pop;
   logic              tx_hv, rx_hv, tx_ovf, rx_ovf;
   logic [STAT_W-1:0] tx_hs, rx_hs;
   logic [LEN_W-1:0]  tx_hl, rx_hl;
   logic [PTR_W-1:0]  tx_cnt, rx_cnt;

   pdq_regfile #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
   ) u_regs (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .tx_len_o(tx_len), .rx_len_o(rx_len),
      .tx_push_o(tx_push), .rx_push_o(rx_push), .tx_pop_o(tx_pop), .rx_pop_o(rx_pop),
      .tx_head_valid_i(tx_hv), .tx_head_status_i(tx_hs),
      .rx_head_valid_i(rx_hv), .rx_head_status_i(rx_hs), .rx_head_len_i(rx_hl),
      .tx_count_i(tx_cnt), .rx_count_i(rx_cnt), .tx_ovf_i(tx_ovf), .rx_ovf_i(rx_ovf)
   );

   pdq_desc_ring #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W), .DEPTH(DEPTH), .STORE_LEN(1'b0)
   ) u_tx_ring (
      .clk, .rst_n,
      .push_i(tx_push), .push_addr_i(reg_wdata[ADDR_W-1:0]), .push_len_i(tx_len),
      .pop_i(tx_pop), .req_allow_i(1'b1), .req_ready_i(tx_req_ready),
      .req_valid_o(tx_req_valid), .req_addr_o(tx_req_addr), .req_len_o(tx_req_len),
      .cpl_valid_i(tx_cpl_valid), .cpl_status_i(tx_cpl_status), .cpl_len_i('0),
      .head_valid_o(tx_hv), .head_status_o(tx_hs), .head_len_o(tx_hl),
      .count_o(tx_cnt), .overflow_o(tx_ovf)
   );

   pdq_desc_ring #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W), .DEPTH(DEPTH), .STORE_LEN(1'b1)
   ) u_rx_ring (
      .clk, .rst_n,
      .push_i(rx_push), .push_addr_i(reg_wdata[ADDR_W-1:0]), .push_len_i(rx_len),
      .pop_i(rx_pop), .req_allow_i(rx_pkt_present), .req_ready_i(rx_req_ready),
      .req_valid_o(rx_req_valid), .req_addr_o(rx_req_addr), .req_len_o(rx_req_len),
      .cpl_valid_i(rx_cpl_valid), .cpl_status_i(rx_cpl_status), .cpl_len_i(rx_cpl_len),
      .head_valid_o(rx_hv), .head_status_o(rx_hs), .head_len_o(rx_hl),
      .count_o(rx_cnt), .overflow_o(rx_ovf)
   );

   logic unused_tx_hl;
   assign unused_tx_hl = ^tx_hl;

   // R3: a receive descriptor is handed off only while a packet waits
   p_rx_handoff_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req_valid && rx_req_ready) |-> (rx_pkt_present && rx_cnt != '0));

endmodule

// File: tb/pdq_regif_test.sv
`timescale 1ns/1ps
module pdq_regif_test;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [2:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        tx_req_valid, rx_req_valid;
   logic        tx_req_ready = 0, rx_req_ready = 0, rx_pkt_present = 0;
   logic [31:0] tx_req_addr, rx_req_addr;
   logic [15:0] tx_req_len, rx_req_len;
   logic        tx_cpl_valid = 0, rx_cpl_valid = 0;
   logic [7:0]  tx_cpl_status = 0, rx_cpl_status = 0;
   logic [15:0] rx_cpl_len = 0;

   always #4 clk = ~clk;

   pdq_regif uut (.*);

   typedef struct { logic [31:0] a; logic [15:0] l; logic [7:0] st; logic [15:0] rl; } ent_t;
   ent_t        q [2][$];
   int          iss [2];
   int          dn  [2];
   bit          ovf [2];
   logic [15:0] lat [2];

   int n_cmp = 0, n_bad = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_status();
      return {8'd0, 8'(q[1].size()), 8'(q[0].size()), 4'd0,
              ovf[1], ovf[0], (dn[1] > 0), (dn[0] > 0)};
   endfunction

   function automatic logic [31:0] exp_rdata();
      if (!reg_rd) return 32'd0;
      case (reg_addr)
         3'd1: return (dn[0] > 0) ? 32'(q[0][0].st) : 32'd0;
         3'd2: return (dn[1] > 0) ? 32'(q[1][0].rl) : 32'd0;
         3'd3: return (dn[1] > 0) ? 32'(q[1][0].st) : 32'd0;
         3'd4: return exp_status();
         3'd5: return 32'(DEPTH);
         default: return 32'd0;
      endcase
   endfunction

   task automatic compare();
      string tag;
      bit    tv, rv;
      case (reg_addr)
         3'd1, 3'd3: tag = "R4 R5 pop";
         3'd2:       tag = "R6 rxlen";
         3'd4:       tag = "R8 status";
         3'd5:       tag = "R9 capacity";
         default:    tag = "R9 other";
      endcase
      chk(tag, reg_rdata, exp_rdata());
      tv = q[0].size() > iss[0];
      rv = rx_pkt_present && (q[1].size() > iss[1]);
      chk("R2 tx valid", 32'(tx_req_valid), 32'(tv));
      chk("R3 rx valid", 32'(rx_req_valid), 32'(rv));
      if (tv) begin
         chk("R1 tx addr", tx_req_addr, q[0][iss[0]].a);
         chk("R1 tx len", 32'(tx_req_len), 32'(q[0][iss[0]].l));
      end
      if (rv) begin
         chk("R1 rx addr", rx_req_addr, q[1][iss[1]].a);
         chk("R1 rx len", 32'(rx_req_len), 32'(q[1][iss[1]].l));
      end
   endtask

   task automatic model();
      for (int d = 0; d < 2; d++) begin
         logic [2:0] qa = (d == 0) ? 3'd1 : 3'd3;
         bit pop  = reg_rd && reg_addr == qa && dn[d] > 0;
         bit pend = q[d].size() > iss[d];
         bit fire = (d == 0) ? (pend && tx_req_ready) : (pend && rx_pkt_present && rx_req_ready);
         bit cv   = (d == 0) ? tx_cpl_valid : rx_cpl_valid;
         bit cpl  = cv && (iss[d] - dn[d]) > 0;
         bit push = reg_wr && reg_addr == qa;
         bit full = q[d].size() == DEPTH;
         if (cpl) begin
            ent_t e = q[d][dn[d]];
            e.st = (d == 0) ? tx_cpl_status : rx_cpl_status;
            if (d == 1) e.rl = rx_cpl_len;
            q[d][dn[d]] = e;
            dn[d]++;
         end
         if (fire) iss[d]++;
         if (push) begin
            if (full) ovf[d] = 1'b1;
            else begin
               ent_t n;
               n.a = reg_wdata; n.l = lat[d]; n.st = 8'd0; n.rl = 16'd0;
               q[d].push_back(n);
            end
         end
         if (pop) begin
            void'(q[d].pop_front());
            dn[d]--;
            iss[d]--;
         end
      end
      if (reg_wr && reg_addr == 3'd0) lat[0] = reg_wdata[15:0];
      if (reg_wr && reg_addr == 3'd2) lat[1] = reg_wdata[15:0];
   endtask

   task automatic tick();
      #1;
      compare();
      model();
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; tx_cpl_valid = 0; rx_cpl_valid = 0;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
   endtask

   task automatic rd_expect(logic [2:0] a, logic [31:0] e, string tag);
      reg_rd = 1; reg_addr = a;
      #1 chk(tag, reg_rdata, e);
      tick();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic tx_done(logic [7:0] s);
      if (iss[0] - dn[0] > 0) begin tx_cpl_valid = 1; tx_cpl_status = s; end
      tick();
   endtask

   task automatic rx_done(logic [7:0] s, logic [15:0] l);
      if (iss[1] - dn[1] > 0) begin rx_cpl_valid = 1; rx_cpl_status = s; rx_cpl_len = l; end
      tick();
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int d = 0; d < 2; d++) begin iss[d] = 0; dn[d] = 0; ovf[d] = 0; lat[d] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10: reset state
      rd_expect(3'd4, 32'd0, "R10 status after reset");
      chk("R10 tx valid", 32'(tx_req_valid), 0);
      chk("R10 rx valid", 32'(rx_req_valid), 0);
      rd_expect(3'd5, 32'(DEPTH), "R9 capacity");
      rd_expect(3'd6, 32'd0, "R9 unused index");

      // Transmit path: R1 length persistence, R2 hold, R4 order, R5 empty pop
      wr(3'd0, 32'd64);
      wr(3'd1, 32'h1000);
      wr(3'd1, 32'h2000);
      wr(3'd0, 32'd100);
      wr(3'd1, 32'h3000);
      rd_expect(3'd1, 32'd0, "R5 pop before completion");
      idle(2);
      tx_req_ready = 1;
      idle(3);
      tx_done(8'd1); tx_done(8'd5); tx_done(8'd1);
      rd_expect(3'd1, 32'd1, "R4 first status");
      rd_expect(3'd1, 32'd5, "R4 second status");
      rd_expect(3'd1, 32'd1, "R4 third status");
      rd_expect(3'd1, 32'd0, "R5 drained");

      // Receive path: R3 gating, R6 length read without pop
      rx_req_ready = 1;
      wr(3'd2, 32'd64);
      wr(3'd3, 32'h8000);
      wr(3'd3, 32'h9000);
      idle(2);
      chk("R3 no packet no request", 32'(rx_req_valid), 0);
      rx_pkt_present = 1;
      idle(2);
      rx_pkt_present = 0;
      rx_done(8'd1, 16'd60);
      rx_done(8'd2, 16'd33);
      rd_expect(3'd2, 32'd60, "R6 length first");
      rd_expect(3'd2, 32'd60, "R6 length no pop");
      rd_expect(3'd3, 32'd1, "R4 rx first");
      rd_expect(3'd2, 32'd33, "R6 length second");
      rd_expect(3'd3, 32'd2, "R4 rx second");
      rd_expect(3'd2, 32'd0, "R6 none left");

      // Overflow: R7
      tx_req_ready = 0;
      wr(3'd0, 32'd16);
      for (int i = 0; i < 5; i++) wr(3'd1, 32'h100 + 32'(i));
      rd_expect(3'd4, 32'h0000_0404, "R7 dropped push flagged");
      tx_req_ready = 1;
      idle(1);
      tx_done(8'd1);
      tx_req_ready = 0;
      rd_expect(3'd1, 32'd1, "R7 pop after overflow");
      wr(3'd1, 32'h200);
      rd_expect(3'd4, 32'h0000_0404, "R7 overflow sticky");
      tx_req_ready = 1;
      idle(5);
      for (int i = 0; i < 4; i++) tx_done(8'd1);
      for (int i = 0; i < 4; i++) rd_expect(3'd1, 32'd1, "R4 drain");

      // Random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         int r = $urandom_range(0, 9);
         rx_pkt_present = 1'($urandom_range(0, 1));
         tx_req_ready   = 1'($urandom_range(0, 1));
         rx_req_ready   = 1'($urandom_range(0, 1));
         if (r < 3) begin
            reg_wr = 1; reg_addr = 3'($urandom_range(0, 3)); reg_wdata = $urandom;
         end else if (r < 6) begin
            reg_rd = 1; reg_addr = 3'($urandom_range(0, 7));
         end
         if (iss[0] - dn[0] > 0 && $urandom_range(0, 2) == 0) begin
            tx_cpl_valid = 1; tx_cpl_status = 8'($urandom_range(1, 4));
         end
         if (iss[1] - dn[1] > 0 && $urandom_range(0, 2) == 0) begin
            rx_cpl_valid = 1; rx_cpl_status = 8'($urandom_range(1, 4));
            rx_cpl_len = 16'($urandom);
         end
         tick();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule